// File: doc/BRIEF.md
# Per-CPU Interrupt Level Combiner

This block serves one processor. It merges four kinds of request into a single pending word, and from that word it drives fifteen level lines, numbered 1 to 15, toward the processor's interrupt input. The four kinds are:

- hard levels that an external system router has already steered to this CPU;
- a level-15 line broadcast to every CPU;
- a local timer line;
- soft interrupts that software raises and lowers through a small word-addressed register port.

There is no level 0, and no line is ever driven for it.

Software reads the pending word at word 0. A write to word 1 lowers soft bits and the latched level-15 flag. A write to word 2 raises soft bits. The soft bits sit in the upper half of the word, and each one feeds the level sixteen places below it. A master-off input comes from the system side. It blocks only the timer and level-15 contributions. Soft requests and routed levels always pass.

Top module: `pil_combiner`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the pending word reads 0 and every level output is 0.
- R2: A read of word 0 returns the pending word, laid out as follows:
  - bits 31..17 hold the soft bits;
  - bit 16 and bit 0 are always 0;
  - bits 15..1 show the routed levels 15..1;
  - bit 14 is also ORed with the timer flag;
  - bit 15 is also ORed with the level-15 flag.

  Reads of words 1, 2 and 3 return 0.
- R3: A write to word 2 ORs data bits 31..17 into the soft bits. All other data bits are dropped.
- R4: A write to word 1 clears each soft bit whose data bit is 1 (bits 31..17), and clears the level-15 flag if data bit 15 is 1. All other data bits are dropped.
- R5: Writes to word 0 and word 3 change nothing.
- R6: The timer flag, which is pending bit 14, follows the timer input.
- R7: The level-15 flag behaves as follows:
  - it sets when the broadcast input rises;
  - it clears when that input falls;
  - a clear write can lower it while the input stays high, and it then stays low until the next rise;
  - if a rise and a clear write occur in the same cycle, the flag sets.
- R8: Level output j (1..15) is the OR of routed level j and soft bit j+16. Output 14 also ORs in the timer flag, and output 15 also ORs in the level-15 flag.
- R9: When master-off is high, the timer and level-15 flags do not reach outputs 14 and 15. Soft bits and routed levels are not affected.
- R10: A change on any input, or a write, shows on the outputs and in the pending word at the first rising clock edge after it, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Word index of the write |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Word index of the read |
| rd_data_o | output | 32 | Read data (combinational from the stored state) |
| routed_lvl_i | input | 15 | Hard levels 15..1 steered to this CPU |
| timer_i | input | 1 | Local timer request |
| bcast15_i | input | 1 | Broadcast level-15 request |
| master_off_i | input | 1 | System master disable |
| irl_o | output | 15 | Level lines 15..1 to the processor |

## Verification
The bench targets the following corner cases, and what a faulty design would show for each:

- **Clear write while the broadcast line stays high.** A design that re-samples the broadcast level would show the flag again at once.
- **Rise and clear in the same cycle.** If the wrong side wins, the flag is lost.
- **Set write with bit 15 or low bits high.** A design without the write mask would put those bits into the pending word.
- **Clear write aimed at bit 14.** A design without the mask would drop the timer flag.
- **Master-off.** A design that gates the whole output would also kill soft and routed levels.
- **The cycle before each edge.** A design that is transparent instead of registered would change its outputs early.

Random traffic then mixes all the sources against a model.

// File: rtl/pil_pkg.sv
// Package: shared constants and register word indices for the per-CPU
// level combiner. Assumes a 32-bit word and 15 levels below the soft field.
package pil_pkg;
    localparam int DW         = 32;
    localparam int NLVL       = 15;
    localparam int SOFT_SHIFT = 16;
    localparam int SOFT_LSB   = SOFT_SHIFT + 1;
    localparam int TMR_BIT    = 14;
    localparam int L15_BIT    = 15;
    localparam int AW         = 2;
    localparam logic [DW-1:0] SOFT_MASK = ~((32'd1 << SOFT_LSB) - 32'd1);

    typedef enum logic [AW-1:0] {
        W_PEND = 2'd0,
        W_CLR  = 2'd1,
        W_SET  = 2'd2,
        W_RSV  = 2'd3
    } word_e;
endpackage

// File: rtl/pil_regs.sv
// Pending-state holder: stores soft bits, the level-15 flag, the timer flag
// and the routed levels, and exposes both the next state (for the output
// stage) and the stored pending word (for readback).
// Assumes one write per cycle; a broadcast edge wins over a clear write.
module pil_regs
    import pil_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [AW-1:0]          wr_addr_i,
    input  logic [DW-1:0]          wr_data_i,
    input  logic [NLVL:1]          routed_i,
    input  logic                   timer_i,
    input  logic                   bcast_i,
    output logic [DW-1:SOFT_LSB]   soft_n_o,
    output logic [NLVL:1]          hard_n_o,
    output logic                   tmr_n_o,
    output logic                   l15_n_o,
    output logic [DW-1:0]          pend_o
);
    logic [DW-1:0] soft_q, soft_d;
    logic [NLVL:1] hard_q;
    logic          tmr_q, l15_q, l15_d, bc_q;
    logic          do_set, do_clr, rise, fall;

    assign do_set = wr_en_i && (wr_addr_i == W_SET);
    assign do_clr = wr_en_i && (wr_addr_i == W_CLR);
    assign rise   = bcast_i && !bc_q;
    assign fall   = !bcast_i && bc_q;

    // Next soft bits: set or clear under the soft mask.
    always_comb begin
        soft_d = soft_q;
        if (do_set)
            soft_d = soft_q | (wr_data_i & SOFT_MASK);
        else if (do_clr)
            soft_d = soft_q & ~(wr_data_i & SOFT_MASK);
    end

    // Next level-15 flag: input edges first, then the clear write.
    always_comb begin
        l15_d = l15_q;
        if (rise)
            l15_d = 1'b1;
        else if (fall)
            l15_d = 1'b0;
        else if (do_clr && wr_data_i[L15_BIT])
            l15_d = 1'b0;
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q <= '0;
            hard_q <= '0;
            tmr_q  <= 1'b0;
            l15_q  <= 1'b0;
            bc_q   <= 1'b0;
        end else begin
            soft_q <= soft_d;
            hard_q <= routed_i;
            tmr_q  <= timer_i;
            l15_q  <= l15_d;
            bc_q   <= bcast_i;
        end
    end

    assign soft_n_o = soft_d[DW-1:SOFT_LSB];
    assign hard_n_o = routed_i;
    assign tmr_n_o  = timer_i;
    assign l15_n_o  = l15_d;

    // Pending word assembly for readback.
    always_comb begin
        pend_o                 = soft_q & SOFT_MASK;
        pend_o[NLVL:1]         = hard_q;
        pend_o[TMR_BIT]        = hard_q[TMR_BIT] | tmr_q;
        pend_o[L15_BIT]        = hard_q[L15_BIT] | l15_q;
    end

    assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        do_set |=> ((pend_o & $past(wr_data_i) & SOFT_MASK) == ($past(wr_data_i) & SOFT_MASK)));

    assert_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        do_clr |=> ((pend_o[DW-1:SOFT_LSB] & $past(wr_data_i[DW-1:SOFT_LSB])) == '0));

    assert_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> pend_o[L15_BIT]);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bcast_i && bc_q && !do_clr) |=> ($past(l15_q) == l15_q));
endmodule

// File: rtl/pil_merge.sv
// Output stage: forms each level line from the next pending state and
// registers it. Master-off gates only the timer and level-15 terms.
// Assumes soft bit j+16 maps to level j and no level 0 exists.
module pil_merge
    import pil_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DW-1:SOFT_LSB] soft_n_i,
    input  logic [NLVL:1]        hard_n_i,
    input  logic                 tmr_n_i,
    input  logic                 l15_n_i,
    input  logic                 master_off_i,
    output logic [NLVL:1]        irl_o
);
    logic [NLVL:1] lvl_d;

    for (genvar j = 1; j <= NLVL; j++) begin : g_lvl
        if (j == TMR_BIT) begin : g_tmr
            assign lvl_d[j] = hard_n_i[j] | soft_n_i[j+SOFT_SHIFT] | (tmr_n_i & !master_off_i);
        end else if (j == L15_BIT) begin : g_l15
            assign lvl_d[j] = hard_n_i[j] | soft_n_i[j+SOFT_SHIFT] | (l15_n_i & !master_off_i);
        end else begin : g_plain
            assign lvl_d[j] = hard_n_i[j] | soft_n_i[j+SOFT_SHIFT];
        end
    end

    // Registered level lines.
    always_ff @(posedge clk) begin
        if (!rst_n) irl_o <= '0;
        else        irl_o <= lvl_d;
    end

    assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (master_off_i && !hard_n_i[TMR_BIT] && !soft_n_i[TMR_BIT+SOFT_SHIFT]) |=> !irl_o[TMR_BIT]);

    assert_soft_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_n_i[1+SOFT_SHIFT] |=> irl_o[1]);

    assert_hard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hard_n_i[NLVL] |=> irl_o[NLVL]);
endmodule

// File: rtl/pil_combiner.sv
// Top of the per-CPU level combiner: state holder, output stage and a
// word-indexed readback mux. Assumes the system router has already applied
// the per-source masks to routed_lvl_i.
module pil_combiner
    import pil_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [1:0]           wr_addr_i,
    input  logic [31:0]          wr_data_i,
    input  logic [1:0]           rd_addr_i,
    output logic [31:0]          rd_data_o,
    input  logic [15:1]          routed_lvl_i,
    input  logic                 timer_i,
    input  logic                 bcast15_i,
    input  logic                 master_off_i,
    output logic [15:1]          irl_o
);
    logic [DW-1:SOFT_LSB] soft_n;
    logic [NLVL:1]        hard_n;
    logic                 tmr_n, l15_n;
    logic [DW-1:0]        pend;

    pil_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .routed_i  (routed_lvl_i),
        .timer_i   (timer_i),
        .bcast_i   (bcast15_i),
        .soft_n_o  (soft_n),
        .hard_n_o  (hard_n),
        .tmr_n_o   (tmr_n),
        .l15_n_o   (l15_n),
        .pend_o    (pend)
    );

    pil_merge u_merge (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_n_i     (soft_n),
        .hard_n_i     (hard_n),
        .tmr_n_i      (tmr_n),
        .l15_n_i      (l15_n),
        .master_off_i (master_off_i),
        .irl_o        (irl_o)
    );

    // Readback: only the pending word is visible.
    always_comb begin
        rd_data_o = (rd_addr_i == W_PEND) ? pend : '0;
    end

    assert_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] == 1'b0) && (pend[SOFT_SHIFT] == 1'b0));

    assert_rst_R1: assert property (@(posedge clk)
        !rst_n |=> (irl_o == '0) && (pend == '0));

    assert_tmr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        timer_i |=> pend[TMR_BIT]);
endmodule

// File: tb/pil_combiner_tb.sv
`timescale 1ns/1ps
module pil_combiner_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [15:1] routed = '0;
    logic        timer = 1'b0, bcast = 1'b0, moff = 1'b0;
    logic [15:1] irl;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    localparam logic [31:0] SMASK = 32'hFFFE_0000;

    logic [31:0] m_soft = '0;
    logic [15:1] m_hard = '0;
    logic        m_tmr = 0, m_l15 = 0, m_bc = 0, m_off = 0;

    always #2.5 clk = ~clk;

    pil_combiner u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .routed_lvl_i(routed), .timer_i(timer), .bcast15_i(bcast),
        .master_off_i(moff), .irl_o(irl)
    );

    function automatic logic [31:0] exp_pend();
        logic [31:0] p;
        p = m_soft & SMASK;
        p[15:1] = m_hard;
        p[14] = m_hard[14] | m_tmr;
        p[15] = m_hard[15] | m_l15;
        return p;
    endfunction

    function automatic logic [15:1] exp_irl();
        logic [15:1] v;
        for (int j = 1; j <= 15; j++) v[j] = m_hard[j] | m_soft[j+16];
        v[14] = v[14] | (m_tmr & !m_off);
        v[15] = v[15] | (m_l15 & !m_off);
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // One clock: model follows the inputs seen at the rising edge.
    task automatic tick();
        @(posedge clk);
        if (!rst_n) begin
            m_soft = '0; m_hard = '0; m_tmr = 0; m_l15 = 0; m_bc = 0; m_off = moff;
        end else begin
            if (wr_en && wr_addr == 2'd2) m_soft = m_soft | (wr_data & SMASK);
            else if (wr_en && wr_addr == 2'd1) m_soft = m_soft & ~(wr_data & SMASK);
            if (bcast && !m_bc) m_l15 = 1;
            else if (!bcast && m_bc) m_l15 = 0;
            else if (wr_en && wr_addr == 2'd1 && wr_data[15]) m_l15 = 0;
            m_bc = bcast; m_tmr = timer; m_hard = routed; m_off = moff;
        end
        @(negedge clk);
    endtask

    task automatic check_all(string req);
        rd_addr = 2'd0;
        #0.5;
        chk(req, rd_data, exp_pend());
        chk(req, {17'd0, irl}, {17'd0, exp_irl()});
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) tick();
        check_all("R1 in reset");
        @(negedge clk); rst_n = 1;
        #0.5;
        chk("R1 after release", rd_data, 32'd0);
        chk("R1 irl after release", {17'd0, irl}, 32'd0);

        // R3: set with all ones keeps only soft bits.
        wr(2'd2, 32'hFFFF_FFFF);
        check_all("R3 set all");
        chk("R8 all soft levels", {17'd0, irl}, {17'd0, 15'h7FFF});

        // R4: clear selected soft bits; low bits dropped.
        wr(2'd1, 32'hAAAA_7FFF);
        check_all("R4 clear");

        // R5: writes to words 0 and 3 ignored.
        wr(2'd0, 32'hFFFF_FFFF);
        check_all("R5 word0");
        wr(2'd3, 32'h0000_FFFF);
        check_all("R5 word3");

        // R10: change not visible before the edge.
        wr(2'd1, 32'hFFFF_FFFF);
        timer = 1;
        #0.5;
        chk("R10 before edge", rd_data, exp_pend());
        tick();
        check_all("R6 timer on");
        chk("R6 bit14", {31'd0, rd_data[14]}, 32'd1);
        // R4: clear write aimed at bit 14 does not lower timer flag.
        wr(2'd1, 32'h0000_4000);
        check_all("R4 bit14 untouched");
        // R9: master off blocks timer level.
        moff = 1; tick();
        check_all("R9 timer gated");
        chk("R9 irl14", {31'd0, irl[14]}, 32'd0);
        timer = 0; moff = 0; tick();

        // R7: broadcast rise, clear while high, re-rise with clear.
        bcast = 1; tick();
        check_all("R7 rise");
        wr(2'd1, 32'h0000_8000);
        check_all("R7 clear while high");
        chk("R7 stays low", {31'd0, rd_data[15]}, 32'd0);
        tick();
        check_all("R7 no re-sample");
        bcast = 0; tick();
        bcast = 1; wr(2'd1, 32'h0000_8000);
        check_all("R7 rise beats clear");
        chk("R7 flag set", {31'd0, rd_data[15]}, 32'd1);
        // R9: off hides level 15 flag.
        moff = 1; tick();
        check_all("R9 l15 gated");
        // R9 / R8: soft and routed pass despite master off.
        routed = 15'h5555; wr(2'd2, 32'h4002_0000);
        check_all("R9 soft and routed pass");
        // R3: set write with bit 15 ignored.
        bcast = 0; moff = 0; tick();
        wr(2'd2, 32'h0000_FFFF);
        check_all("R3 bit15 dropped");

        // R2: other words read zero.
        for (int a = 1; a < 4; a++) begin
            rd_addr = a[1:0];
            #0.5;
            chk("R2 other word", rd_data, 32'd0);
        end

        // Random traffic.
        for (int i = 0; i < 4000; i++) begin
            wr_en   = ($urandom % 3) == 0;
            wr_addr = 2'($urandom);
            wr_data = $urandom;
            routed  = (($urandom % 2) == 0) ? 15'($urandom) : '0;
            timer   = ($urandom % 4) == 0;
            bcast   = ($urandom % 5) == 0 ? ~bcast : bcast;
            moff    = ($urandom % 6) == 0;
            tick();
            wr_en = 0;
            check_all("R8 random");
            rd_addr = 2'($urandom);
            #0.5;
            chk("R2 random read", rd_data, (rd_addr == 0) ? exp_pend() : 32'd0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule